// File: doc/BRIEF.md
# Packed Lane Minimum/Maximum Unit

This unit takes two 128-bit operands and an 8-bit operation code and produces a 128-bit result in which every lane holds either the larger or the smaller of the two matching input lanes. Four codes are recognised. Two of them treat the operands as eight signed 16-bit lanes. The other two treat them as sixteen unsigned 8-bit lanes. Operand A sits in the destination position, so an unknown code returns A untouched and raises an illegal flag.

One bank of byte comparators serves both lane widths. For word lanes, the sign bit of each high byte is inverted, and the verdicts of the high and low bytes are chained into one word verdict. Operations enter through a valid/ready pair. Results leave through a registered valid/ready pair one cycle after acceptance. A new operation may be accepted in every cycle in which the output register is empty or being drained.

Top module: `pmm_unit`

## Requirements
- R1: Code 8'hEE returns, in each 16-bit lane i (bits 16i+15..16i), the signed-greater of the A and B lanes.
- R2: Code 8'hDE returns, in each 8-bit lane i (bits 8i+7..8i), the unsigned-greater of the A and B lanes.
- R3: Code 8'hEA returns, in each 16-bit lane, the signed-smaller of the A and B lanes.
- R4: Code 8'hDA returns, in each 8-bit lane, the unsigned-smaller of the A and B lanes.
- R5: When an A lane equals the matching B lane, the result lane equals that common value in every mode.
- R6: Any other code yields out_illegal = 1 and out_result equal to operand A. The four codes above yield out_illegal = 0.
- R7: An operation accepted at a clock edge (in_valid and in_ready both high) is presented with out_valid = 1 right after that same edge.
- R8: While out_valid is high and out_ready is low, out_valid, out_result and out_illegal keep their values at the next edge.
- R9: After reset, out_valid is 0 and in_ready is 1.
- R10: in_ready equals (not out_valid) or out_ready, so one operation per cycle is accepted when the output drains every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation |
| in_opcode | input | 8 | Operation code |
| in_a | input | 128 | Operand A, also the pass-through value |
| in_b | input | 128 | Operand B |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 128 | Lane-wise result |
| out_illegal | output | 1 | Code was not recognised |

## Verification
The bench pairs 16'h8000 with 16'h7FFF and 8'hFF with 8'h00. A comparator that confused signed and unsigned order, or that did not invert the high-byte sign for word lanes, would return the wrong lane for these values. Word lanes whose high bytes are equal and whose low bytes differ expose a broken chaining of the high and low verdicts. A design that compared only one byte would pick the wrong half. Neighbouring codes such as 8'hEF and 8'hDB must be rejected and pass A through, which catches a decoder that looks at too few bits. Random back-pressure checks that a stalled result stays frozen and that latency stays one cycle; a faulty handshake would drop results or duplicate them.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
    localparam logic [7:0] OPC_SMAX_W = 8'hEE;
    localparam logic [7:0] OPC_UMAX_B = 8'hDE;
    localparam logic [7:0] OPC_SMIN_W = 8'hEA;
    localparam logic [7:0] OPC_UMIN_B = 8'hDA;

    typedef struct packed {
        logic word_mode;
        logic take_max;
        logic legal;
    } pmm_ctl_t;
endpackage

// File: rtl/pmm_decode.sv
module pmm_decode
    import pmm_pkg::*;
(
    input  logic [7:0] opcode,
    output pmm_ctl_t   ctl
);
    always_comb begin
        ctl = '{word_mode: 1'b0, take_max: 1'b0, legal: 1'b0};
        case (opcode)
            OPC_SMAX_W: ctl = '{word_mode: 1'b1, take_max: 1'b1, legal: 1'b1};
            OPC_UMAX_B: ctl = '{word_mode: 1'b0, take_max: 1'b1, legal: 1'b1};
            OPC_SMIN_W: ctl = '{word_mode: 1'b1, take_max: 1'b0, legal: 1'b1};
            OPC_UMIN_B: ctl = '{word_mode: 1'b0, take_max: 1'b0, legal: 1'b1};
            default:    ctl = '{word_mode: 1'b0, take_max: 1'b0, legal: 1'b0};
        endcase
    end
endmodule

// File: rtl/pmm_cmp_array.sv
module pmm_cmp_array #(
    parameter int BYTES = 16
) (
    input  logic [BYTES*8-1:0] a,
    input  logic [BYTES*8-1:0] b,
    input  logic               word_mode,
    output logic [BYTES-1:0]   lane_gt
);
    localparam int WORDS = BYTES / 2;

    logic [BYTES-1:0] byte_gt;
    logic [WORDS-1:0] hi_eq;

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        logic       flip;
        logic [7:0] ka;
        logic [7:0] kb;
        // Inverting the sign bit maps signed order onto unsigned order
        assign flip = word_mode && ((i % 2) == 1);
        assign ka   = {a[8*i+7] ^ flip, a[8*i+6 -: 7]};
        assign kb   = {b[8*i+7] ^ flip, b[8*i+6 -: 7]};
        assign byte_gt[i] = ka > kb;
        if ((i % 2) == 1) begin : g_hi
            assign hi_eq[i/2] = ka == kb;
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic word_gt;
        assign word_gt = byte_gt[2*w+1] | (hi_eq[w] & byte_gt[2*w]);
        assign lane_gt[2*w]   = word_mode ? word_gt : byte_gt[2*w];
        assign lane_gt[2*w+1] = word_mode ? word_gt : byte_gt[2*w+1];
    end
endmodule

// File: rtl/pmm_lane_mux.sv
module pmm_lane_mux #(
    parameter int BYTES = 16
) (
    input  logic [BYTES*8-1:0] a,
    input  logic [BYTES*8-1:0] b,
    input  logic [BYTES-1:0]   lane_gt,
    input  logic               take_max,
    output logic [BYTES*8-1:0] result
);
    for (genvar i = 0; i < BYTES; i++) begin : g_sel
        // A wins when its verdict matches the wanted direction
        assign result[8*i +: 8] = (lane_gt[i] == take_max) ? a[8*i +: 8] : b[8*i +: 8];
    end
endmodule

// File: rtl/pmm_unit.sv
module pmm_unit
    import pmm_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_opcode,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_result,
    output logic              out_illegal
);
    localparam int BYTES = DATA_W / 8;

    typedef struct packed {
        logic              valid;
        logic              illegal;
        logic [DATA_W-1:0] result;
    } pmm_state_t;

    pmm_state_t        st_d, st_q;
    pmm_ctl_t          ctl;
    logic [BYTES-1:0]  lane_gt;
    logic [DATA_W-1:0] lane_res;

    pmm_decode u_decode (
        .opcode (in_opcode),
        .ctl    (ctl)
    );

    pmm_cmp_array #(.BYTES(BYTES)) u_cmp (
        .a         (in_a),
        .b         (in_b),
        .word_mode (ctl.word_mode),
        .lane_gt   (lane_gt)
    );

    pmm_lane_mux #(.BYTES(BYTES)) u_mux (
        .a        (in_a),
        .b        (in_b),
        .lane_gt  (lane_gt),
        .take_max (ctl.take_max),
        .result   (lane_res)
    );

    assign in_ready = !st_q.valid || out_ready;

    always_comb begin
        st_d = st_q;
        if (in_ready) begin
            st_d.valid = in_valid;
            if (in_valid) begin
                st_d.illegal = !ctl.legal;
                st_d.result  = ctl.legal ? lane_res : in_a;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_result  = st_q.result;
    assign out_illegal = st_q.illegal;

    assert_accept_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

    assert_no_accept_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_illegal_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !ctl.legal) |=> (out_illegal && out_result == $past(in_a)));

    assert_legal_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && ctl.legal) |=> !out_illegal);
endmodule

// File: tb/pmm_unit_bench.sv
module pmm_unit_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [7:0]   in_opcode = 8'h00;
    logic [127:0] in_a = '0;
    logic [127:0] in_b = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_result;
    logic         out_illegal;

    int checks = 0;
    int errors = 0;
    int cycle = 0;
    bit stall_mode = 1'b0;
    logic [31:0] lfsr = 32'h1234_5678;

    typedef struct {
        logic [127:0] res;
        logic         ill;
        int           stamp;
        string        tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    pmm_unit u_pmm_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_opcode(in_opcode), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_ready(out_ready), .out_result(out_result), .out_illegal(out_illegal)
    );

    always @(posedge clk) cycle <= cycle + 1;

    function automatic logic [31:0] next_rand(logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic [127:0] model(logic [7:0] op, logic [127:0] a, logic [127:0] b);
        logic [127:0] r;
        r = a;
        for (int w = 0; w < 8; w++) begin
            if (op == 8'hEE) r[16*w +: 16] = ($signed(a[16*w +: 16]) > $signed(b[16*w +: 16])) ? a[16*w +: 16] : b[16*w +: 16];
            if (op == 8'hEA) r[16*w +: 16] = ($signed(a[16*w +: 16]) < $signed(b[16*w +: 16])) ? a[16*w +: 16] : b[16*w +: 16];
        end
        for (int i = 0; i < 16; i++) begin
            if (op == 8'hDE) r[8*i +: 8] = (a[8*i +: 8] > b[8*i +: 8]) ? a[8*i +: 8] : b[8*i +: 8];
            if (op == 8'hDA) r[8*i +: 8] = (a[8*i +: 8] < b[8*i +: 8]) ? a[8*i +: 8] : b[8*i +: 8];
        end
        return r;
    endfunction

    function automatic string op_tag(logic [7:0] op);
        case (op)
            8'hEE: return "R1";
            8'hDE: return "R2";
            8'hEA: return "R3";
            8'hDA: return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: offer one operation, push expected item when accepted
    task automatic send(logic [7:0] op, logic [127:0] a, logic [127:0] b, string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_opcode = op; in_a = a; in_b = b;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        e.res = model(op, a, b);
        e.ill = !(op == 8'hEE || op == 8'hDE || op == 8'hEA || op == 8'hDA);
        e.stamp = cycle + 1;
        e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    // back-pressure generator
    always @(negedge clk) begin
        lfsr <= next_rand(lfsr);
        out_ready <= stall_mode ? lfsr[3] : 1'b1;
    end

    // monitor / scoreboard
    bit head_seen = 1'b0;
    bit hold_prev = 1'b0;
    logic [127:0] saved_res;
    logic saved_ill;
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                check(in_ready == (!out_valid || out_ready), "R10", {127'd0, in_ready}, {127'd0, (!out_valid || out_ready)});
                if (hold_prev) begin
                    check(out_valid && out_result == saved_res && out_illegal == saved_ill, "R8",
                          out_result, saved_res);
                end
                hold_prev = 1'b0;
                if (out_valid) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R7", {127'd0, out_valid}, 128'd0);
                    end else begin
                        if (!head_seen) begin
                            check(cycle == sb[0].stamp, "R7", 128'(cycle), 128'(sb[0].stamp));
                            head_seen = 1'b1;
                        end
                        if (out_ready) begin
                            check(out_result == sb[0].res, sb[0].tag, out_result, sb[0].res);
                            check(out_illegal == sb[0].ill, sb[0].tag, {127'd0, out_illegal}, {127'd0, sb[0].ill});
                            void'(sb.pop_front());
                            head_seen = 1'b0;
                        end else begin
                            hold_prev = 1'b1;
                            saved_res = out_result;
                            saved_ill = out_illegal;
                        end
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] ra, rb;
        logic [7:0] ops [4] = '{8'hEE, 8'hDE, 8'hEA, 8'hDA};
        logic [31:0] s;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(out_valid == 1'b0 && in_ready == 1'b1, "R9", {126'd0, out_valid, in_ready}, 128'd1);

        // signed extremes: 8000 vs 7FFF, FFFF vs 0001
        ra = {8{16'h8000}}; rb = {8{16'h7FFF}};
        send(8'hEE, ra, rb, "R1");
        send(8'hEA, ra, rb, "R3");
        ra = {4{16'hFFFF, 16'h0001}}; rb = {4{16'h0001, 16'hFFFF}};
        send(8'hEE, ra, rb, "R1");
        send(8'hEA, ra, rb, "R3");
        // equal high bytes, low bytes decide the word
        ra = {8{16'h12F0}}; rb = {8{16'h120F}};
        send(8'hEE, ra, rb, "R1");
        send(8'hEA, rb, ra, "R3");
        // unsigned bytes FF vs 00 vs 80
        ra = {8{8'hFF, 8'h00}}; rb = {8{8'h00, 8'h80}};
        send(8'hDE, ra, rb, "R2");
        send(8'hDA, ra, rb, "R4");
        // equal lanes
        ra = 128'h8000_7FFF_FF00_0001_1234_ABCD_0000_FFFF;
        foreach (ops[k]) send(ops[k], ra, ra, "R5");
        // unknown codes, including neighbours of valid ones
        send(8'h00, ra, ~ra, "R6");
        send(8'hEF, ra, ~ra, "R6");
        send(8'hDB, ra, ~ra, "R6");
        send(8'hFA, ra, ~ra, "R6");

        // random traffic under back-pressure
        stall_mode = 1'b1;
        s = 32'hACE1_0001;
        for (int n = 0; n < 300; n++) begin
            logic [7:0] op;
            for (int q = 0; q < 4; q++) begin
                s = next_rand(s); ra[32*q +: 32] = s;
                s = next_rand(s); rb[32*q +: 32] = s;
            end
            s = next_rand(s);
            op = (s[2:0] == 3'd7) ? s[15:8] : ops[s[1:0]];
            send(op, ra, rb, op_tag(op));
        end
        stall_mode = 1'b0;
        while (sb.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule